// File: doc/BRIEF.md
# Clocked Host Controller for an 8K x 8 Asynchronous Static RAM

This block lets synchronous logic use an external asynchronous static RAM that holds 8192 bytes. The host sends one request at a time over a valid/ready channel. A request carries a read/write flag, a 13-bit address and a write byte. The controller then works through the memory's strobe sequence, and it returns every finished access on a valid/ready response channel. A read returns its byte there, and a write returns a plain completion.

The memory has two selects of opposite polarity. It is enabled only when the low-active select is low and the high-active select is high. An asserted write strobe forces a write whatever the output enable is doing. The memory's analogue limits are given as picosecond parameters next to the clock period: cycle time, address access, output-enable access, output float delays, write pulse width and data setup. Each limit is turned into a whole number of clock cycles by rounding up, so the sequence is correct for any clock the block runs on.

Back-pressure rules: `req_ready` is high only when the controller is idle and the minimum cycle time since the last address change has elapsed. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The response stays valid, with its data unchanged, until `rsp_ready` is sampled high. No new request is taken until that happens.

Top module: `sram_ctl`

## Requirements
- R1: After reset both selects are inactive (`mem_cs_n`=1, `mem_cs`=0), `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: The selects are active (`mem_cs_n`=0 and `mem_cs`=1) from the accept edge until the edge that raises `rsp_valid`, and both are inactive from that edge on and whenever the controller is idle.
- R3: For a read, `mem_oe_n` is low and `mem_we_n` is high from the accept edge. The data bus is sampled RD cycles after the accept edge, where RD is the larger of the rounded address access count and the rounded output-enable access count. `rsp_valid` rises on that same edge, carrying the sampled byte.
- R4: For a write, `mem_oe_n` is high from the accept edge. `mem_we_n` falls TA cycles after acceptance, where TA is the larger of the two rounded output float counts, and `mem_dq_oe` rises on the same edge. `mem_we_n` stays low for PW cycles, where PW is the larger of the rounded pulse width and data setup counts, with `mem_dq_out` held steady. The data stays driven one more cycle after `mem_we_n` rises, and it is released on the edge that raises `rsp_valid`.
- R5: `mem_we_n` is never low while `mem_oe_n` is low, and `mem_dq_oe` is never high while `mem_oe_n` is low.
- R6: `mem_addr` changes only on an accept edge. Two accept edges are at least CYC cycles apart, where CYC is the rounded cycle time, even when the controller has gone idle sooner.
- R7: `rsp_valid` stays high with `rsp_rdata` unchanged until `rsp_ready` is sampled high. `req_ready` stays low while a response is pending.
- R8: Every cycle count is the limit divided by the clock period, rounded up. For example, a 10 ns limit with a 4 ns clock gives 3 cycles.
- R9: Every address in the 13-bit range can be written and read back: a read returns the byte most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | Access finished; read byte valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 8 | Byte returned by the last read |
| mem_addr | output | 13 | Memory address bus |
| mem_cs_n | output | 1 | Low-active memory select |
| mem_cs | output | 1 | High-active memory select |
| mem_we_n | output | 1 | Low-active write strobe |
| mem_oe_n | output | 1 | Low-active output enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | High while the controller drives the data bus |
| mem_dq_in | input | 8 | Data read from the memory bus |

## Verification
Counted from the accept edge, a read response is due RD edges later and a write response TA+PW+1 edges later. The write strobe falls after TA edges and stays low for PW cycles, and `req_ready` comes back no sooner than CYC edges after the accept. The bench takes these counts from the picosecond parameters with its own ceiling arithmetic. It drives each request half a cycle before its accept edge and then counts edges, sampling at every falling clock edge. This gives the exact edge on which the strobe falls, how long it stays low, the edge of the response and the edge on which `req_ready` returns. A bus model in the bench commits a byte on each rising write strobe and flags any cycle where the controller drives the bus while the memory could also be driving it.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  // Controller phases
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_WR_TURN,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_RESP
  } ctl_state_t;

  // Whole clock cycles that cover a limit given in picoseconds (at least one)
  function automatic int cycles_for(input int limit_ps, input int clk_ps);
    int c;
    c = (limit_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_span.sv
// Loadable down-counter; 'expired' once the loaded number of edges has passed.
module sram_ctl_span #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt <= CW'(1));

  // R8: a nonzero load is never seen as already expired on the next cycle unless it was one
  p_span_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (load_val > CW'(1))) |=> !expired);

endmodule

// File: rtl/sram_ctl_seq.sv
// Strobe sequencer: host handshake, pin registers, read capture.
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int AW   = 13,
  parameter int DW   = 8,
  parameter int CW   = 4,
  parameter int N_RD = 1,
  parameter int N_TA = 1,
  parameter int N_PW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  input  logic          gap_ok,
  input  logic          phase_done,
  output logic          accept,
  output logic          phase_load,
  output logic [CW-1:0] phase_val,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_cs,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  ctl_state_t state;

  assign req_ready = (state == ST_IDLE) && gap_ok;
  assign accept    = req_valid && req_ready;

  always_comb begin
    phase_load = accept || ((state == ST_WR_TURN) && phase_done);
    if (accept) begin
      phase_val = req_write ? CW'(N_TA) : CW'(N_RD);
    end else begin
      phase_val = CW'(N_PW);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mem_addr   <= '0;
      mem_cs_n   <= 1'b1;
      mem_cs     <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            mem_addr   <= req_addr;
            mem_cs_n   <= 1'b0;
            mem_cs     <= 1'b1;
            mem_oe_n   <= req_write;
            mem_dq_out <= req_wdata;
            state      <= req_write ? ST_WR_TURN : ST_RD_WAIT;
          end
        end
        ST_RD_WAIT: begin
          if (phase_done) begin
            rsp_rdata <= mem_dq_in;
            rsp_valid <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_cs_n  <= 1'b1;
            mem_cs    <= 1'b0;
            state     <= ST_RESP;
          end
        end
        ST_WR_TURN: begin
          if (phase_done) begin
            mem_we_n  <= 1'b0;
            mem_dq_oe <= 1'b1;
            state     <= ST_WR_PULSE;
          end
        end
        ST_WR_PULSE: begin
          if (phase_done) begin
            mem_we_n <= 1'b1;
            state    <= ST_WR_HOLD;
          end
        end
        ST_WR_HOLD: begin
          mem_dq_oe <= 1'b0;
          mem_cs_n  <= 1'b1;
          mem_cs    <= 1'b0;
          rsp_valid <= 1'b1;
          state     <= ST_RESP;
        end
        ST_RESP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: no select while idle
  p_idle_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!mem_cs && mem_cs_n));

  // R5: write strobe and controller drive only with the output enable released
  p_we_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  p_drive_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R4: data driven and steady throughout the strobe
  p_strobe_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);
  p_strobe_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> $stable(mem_dq_out));

  // R6: the address moves only on an accept edge
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(mem_addr));

  // R7: response held until taken
  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  p_no_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW              = 13,
  parameter int DW              = 8,
  parameter int CLK_PERIOD_PS   = 20000,
  parameter int T_CYCLE_PS      = 12000,
  parameter int T_ACCESS_PS     = 12000,
  parameter int T_OE_VALID_PS   = 6000,
  parameter int T_OE_FLOAT_PS   = 6000,
  parameter int T_WE_FLOAT_PS   = 7000,
  parameter int T_STROBE_PS     = 10000,
  parameter int T_DATA_SETUP_PS = 7000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_cs,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int N_RD  = max2(cycles_for(T_ACCESS_PS, CLK_PERIOD_PS),
                              cycles_for(T_OE_VALID_PS, CLK_PERIOD_PS));
  localparam int N_TA  = max2(cycles_for(T_OE_FLOAT_PS, CLK_PERIOD_PS),
                              cycles_for(T_WE_FLOAT_PS, CLK_PERIOD_PS));
  localparam int N_PW  = max2(cycles_for(T_STROBE_PS, CLK_PERIOD_PS),
                              cycles_for(T_DATA_SETUP_PS, CLK_PERIOD_PS));
  localparam int N_CYC = cycles_for(T_CYCLE_PS, CLK_PERIOD_PS);
  localparam int N_MAX = max2(max2(N_RD, N_TA), max2(N_PW, N_CYC));
  localparam int CW    = $clog2(N_MAX + 1);

  logic          accept;
  logic          phase_load;
  logic [CW-1:0] phase_val;
  logic          phase_done;
  logic          gap_ok;

  sram_ctl_span #(.CW(CW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (phase_load),
    .load_val (phase_val),
    .expired  (phase_done)
  );

  sram_ctl_span #(.CW(CW)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (CW'(N_CYC)),
    .expired  (gap_ok)
  );

  sram_ctl_seq #(
    .AW(AW), .DW(DW), .CW(CW),
    .N_RD(N_RD), .N_TA(N_TA), .N_PW(N_PW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .gap_ok     (gap_ok),
    .phase_done (phase_done),
    .accept     (accept),
    .phase_load (phase_load),
    .phase_val  (phase_val),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_cs     (mem_cs),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in)
  );

endmodule

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;

  // Timing point exercised: 4 ns cycles as seen by the count arithmetic
  localparam int CLK_PS = 4000;
  localparam int TCYC = 32000, TAA = 12000, TOEV = 6000, TOEF = 6000,
                 TWEF = 7000, TWP = 10000, TDS = 7000;

  function automatic int up(input int t);
    int c;
    c = t / CLK_PS;
    if (c * CLK_PS < t) c = c + 1;
    if (c < 1) c = 1;
    return c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD  = mx(up(TAA), up(TOEV));   // 3
  localparam int E_TA  = mx(up(TOEF), up(TWEF));  // 2
  localparam int E_PW  = mx(up(TWP), up(TDS));    // 3
  localparam int E_CYC = up(TCYC);                // 8

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [12:0] mem_addr;

  always #10 clk = ~clk;  // 50 MHz

  sram_ctl #(
    .CLK_PERIOD_PS(CLK_PS), .T_CYCLE_PS(TCYC), .T_ACCESS_PS(TAA),
    .T_OE_VALID_PS(TOEV), .T_OE_FLOAT_PS(TOEF), .T_WE_FLOAT_PS(TWEF),
    .T_STROBE_PS(TWP), .T_DATA_SETUP_PS(TDS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Bus model of the memory
  logic [7:0] marr [8192];
  logic       prev_we_n = 1'b1;
  int         clash = 0;
  wire        sel = mem_cs && !mem_cs_n;
  assign mem_dq_in = (sel && !mem_oe_n && mem_we_n) ? marr[mem_addr] : 8'hzz;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_we_n === 1'b0 && mem_we_n === 1'b1 && sel && mem_dq_oe)
        marr[mem_addr] = mem_dq_out;
      if (mem_dq_oe && !mem_oe_n) clash++;
      if (!mem_we_n && !mem_oe_n) clash++;
    end
    prev_we_n = mem_we_n;
  end

  int checks = 0, fails = 0, cyc = 0;
  bit ended = 0;

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, cycles %0d expected below %0d", cyc, 150000);
      finish_up();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'((a * 37) ^ (a >> 5) ^ salt);
  endfunction

  int last_n;
  logic [7:0] last_rd;

  // Issue one access; check its edge timing; leave at the falling edge where rsp_valid shows
  task automatic do_op(input bit wr, input logic [12:0] a, input logic [7:0] d);
    int n, we_first, we_len;
    bit sel_ok, oe_ok, steady;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; we_first = -1; we_len = 0; sel_ok = 1; oe_ok = 1; steady = 1;
    while (!rsp_valid && n < 100) begin
      if (!sel || mem_addr != a) sel_ok = 0;
      if (wr ? !mem_oe_n : mem_oe_n) oe_ok = 0;
      if (!mem_we_n) begin
        if (we_first < 0) we_first = n;
        we_len++;
        if (!mem_dq_oe || mem_dq_out != d) steady = 0;
      end
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    last_n = n;
    last_rd = rsp_rdata;
    chk(sel_ok, "R2", "selects active with address during access", sel_ok, 1);
    chk(!sel && mem_cs_n && !mem_cs, "R2", "selects released with response", sel, 0);
    chk(!mem_dq_oe, "R4", "bus released at response", mem_dq_oe, 0);
    if (wr) begin
      chk(oe_ok, "R4", "output enable high through write", oe_ok, 1);
      chk(we_first == E_TA, "R4", "strobe falls after turnaround", we_first, E_TA);
      chk(we_len == E_PW, "R8", "strobe width in cycles", we_len, E_PW);
      chk(steady, "R4", "data driven and steady in strobe", steady, 1);
      chk(n == E_TA + E_PW + 1, "R4", "write response edge", n, E_TA + E_PW + 1);
    end else begin
      chk(oe_ok, "R3", "output enable low through read", oe_ok, 1);
      chk(we_first < 0, "R3", "no strobe during read", we_first, -1);
      chk(n == E_RD, "R3", "read response edge", n, E_RD);
    end
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) marr[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(mem_cs_n && !mem_cs, "R1", "selects idle in reset", mem_cs, 0);
    chk(mem_we_n && mem_oe_n && !mem_dq_oe, "R1", "strobes idle in reset", mem_we_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R1", "ready after reset", req_ready, 1);

    // R3/R4 simple pair
    do_op(1'b1, 13'h0AB, 8'h5C);
    do_op(1'b0, 13'h0AB, 8'h00);
    chk(last_rd == 8'h5C, "R3", "read byte", last_rd, 8'h5C);

    // R6: gap from accept edge to next ready, counted from the read above
    begin
      int k;
      do_op(1'b0, 13'h0AB, 8'h00);
      k = last_n;
      while (!req_ready && k < 100) begin
        @(posedge clk); @(negedge clk); k++;
      end
      chk(k + 1 == E_CYC, "R6", "accept spacing in cycles", k + 1, E_CYC);
    end

    // R7: back-pressure on the response
    begin
      bit held;
      rsp_ready = 1'b0;
      do_op(1'b0, 13'h0AB, 8'h00);
      held = 1;
      req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h1FFF; req_wdata = 8'hEE;
      for (int i = 0; i < 5; i++) begin
        @(posedge clk); @(negedge clk);
        if (!rsp_valid || rsp_rdata != 8'h5C || req_ready || mem_addr != 13'h0AB) held = 0;
      end
      req_valid = 1'b0;
      chk(held, "R7", "response held, request refused", held, 1);
      rsp_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(!rsp_valid, "R7", "response drops after take", rsp_valid, 0);
      chk(marr[13'h1FFF] == 8'h00, "R7", "refused write left memory untouched",
          marr[13'h1FFF], 0);
    end

    // R9: sweep of the address range, both ends included
    for (int a = 0; a < 8192; a += 7) do_op(1'b1, 13'(a), pat(a, 0));
    do_op(1'b1, 13'h1FFF, pat(8191, 0));
    for (int a = 0; a < 8192; a += 7) begin
      do_op(1'b0, 13'(a), 8'h00);
      chk(last_rd == pat(a, 0), "R9", "read back after sweep", last_rd, pat(a, 0));
    end
    do_op(1'b0, 13'h1FFF, 8'h00);
    chk(last_rd == pat(8191, 0), "R9", "top address", last_rd, pat(8191, 0));

    // R9: overwrite keeps the latest byte
    do_op(1'b1, 13'h0000, 8'hA5);
    do_op(1'b1, 13'h0000, 8'h3C);
    do_op(1'b0, 13'h0000, 8'h00);
    chk(last_rd == 8'h3C, "R9", "latest write wins", last_rd, 8'h3C);

    // R5: no contention cycle seen anywhere
    chk(clash == 0, "R5", "bus contention cycles", clash, 0);
    finish_up();
  end

endmodule